// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital sequencer of a successive-approximation converter. A one-cycle start request, taken while the block is idle, clears the trial register and begins a bit-by-bit search. The search starts at the most significant bit. In each clock cycle the block presents a trial code to an external DAC. It then samples a single comparator decision and either keeps or drops the bit under test.

A mode bit is captured when the start is accepted. It selects either a full 12-bit search or a short search that resolves only the upper 8 bits. A busy flag covers the whole conversion. Start requests that arrive during a conversion have no effect. When the search finishes, the code moves into a result register, a one-cycle end pulse fires, and the data-valid flag rises. The result output reads zero whenever the data is not valid.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy_o, eoc_o and valid_o are 0, and result_o and trial_o are all zeros.
- R2: start_i high at a rising edge while busy_o is low starts a conversion. In the next cycle busy_o is 1 and trial_o is 0x800: the register is cleared and only bit 11 is set.
- R3: One bit is tried per cycle, from bit 11 downward. The trial code is the bits decided so far, plus the bit under test set to 1. If cmp_i=1 (the DAC sum is below the input), that bit stays 1 at the next edge. If cmp_i=0, it is cleared.
- R4: With short_i=0 at start, all 12 bits are resolved. With an ideal comparator (cmp_i = trial_o <= input code), result_o equals the input code.
- R5: With short_i=1 at start, only bits 11..4 are resolved. Bits 3..0 of trial_o and result_o stay 0, so the result is the input code with its low 4 bits zeroed.
- R6: busy_o stays high for 13 cycles in full mode and 9 cycles in short mode, counted from the first cycle after start acceptance.
- R7: While busy_o is high, start_i and short_i are ignored. The running conversion keeps its mode and result, and it does not restart. No new conversion begins after it ends.
- R8: While busy_o is high, valid_o is 0 and result_o reads 0.
- R9: eoc_o is high for exactly one cycle, the first cycle in which busy_o is low again. From that cycle valid_o is 1 and result_o shows the new code.
- R10: The result is held unchanged until the next conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled at rising edge |
| short_i | input | 1 | 1 selects the 8-bit short search, captured at start |
| cmp_i | input | 1 | Comparator decision, 1 = DAC sum below input |
| trial_o | output | 12 | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| valid_o | output | 1 | Result valid |
| result_o | output | 12 | Final code, zero when not valid |

## Verification
The bench uses input codes that stress the search path: all zeros, all ones, the codes on either side of the midpoint, and alternating bit patterns. A design that tests bits in the wrong order, or that keeps bits on the wrong comparator polarity, returns a code other than the input. Short-mode runs use inputs whose low nibble is nonzero. A design that does not stop at bit 4 leaks those bits into the result, and one that does not latch the mode is caught when short_i is flipped mid-run. The bench also pulses start_i mid-conversion and measures busy length. A design that restarts, stretches busy or chains a second conversion shows the wrong cycle count or a busy flag that stays high after the end pulse.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LATCH = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic short_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic latch_o,
  output logic busy_o,
  output logic short_q_o
);
  sar_state_e state_q, state_d;
  logic       short_q;

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign step_o  = (state_q == ST_RUN);
  assign latch_o = (state_q == ST_LATCH);
  assign busy_o  = (state_q != ST_IDLE);
  assign short_q_o = short_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RUN;
      ST_RUN:   if (last_i)  state_d = ST_LATCH;
      ST_LATCH: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) short_q <= short_i;  // mode frozen for the whole run
    end
  end
endmodule

// File: rtl/sar_ptr.sv
module sar_ptr #(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8,
  localparam int PTR_W  = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             short_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             last_o
);
  localparam logic [PTR_W-1:0] TOP       = PTR_W'(RES_W - 1);
  localparam logic [PTR_W-1:0] STOP_FULL = '0;
  localparam logic [PTR_W-1:0] STOP_SHRT = PTR_W'(RES_W - SHORT_W);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] stop;

  assign stop   = short_i ? STOP_SHRT : STOP_FULL;
  assign last_o = step_i && (ptr_q == stop);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= TOP;
    else if (load_i)            ptr_q <= TOP;
    else if (step_i && !last_o) ptr_q <= ptr_q - 1'b1;
  end
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int RES_W  = 12,
  localparam int PTR_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [RES_W-1:0] code_o,
  output logic [RES_W-1:0] trial_o
);
  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] probe;

  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    assign probe[i] = step_i && (ptr_i == PTR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       code_q[i] <= 1'b0;
      else if (load_i)   code_q[i] <= 1'b0;
      else if (probe[i]) code_q[i] <= cmp_i;
    end
  end

  assign code_o  = code_q;
  assign trial_o = code_q | probe;
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             latch_i,
  input  logic [RES_W-1:0] code_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             eoc_o
);
  logic [RES_W-1:0] res_q;
  logic             valid_q, eoc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      eoc_q <= latch_i;
      if (latch_i) begin
        res_q   <= code_i;
        valid_q <= 1'b1;
      end else if (load_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign result_o = valid_q ? res_q : '0;
  assign valid_o  = valid_q;
  assign eoc_o    = eoc_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8,
  localparam int PTR_W  = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             busy_o,
  output logic             eoc_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);
  logic             load, step, latch, last, short_q;
  logic [PTR_W-1:0] ptr;
  logic [RES_W-1:0] code;

  sar_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .short_i,
    .last_i(last), .load_o(load), .step_o(step), .latch_o(latch),
    .busy_o, .short_q_o(short_q)
  );

  sar_ptr #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_ptr (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .short_i(short_q),
    .ptr_o(ptr), .last_o(last)
  );

  sar_reg #(.RES_W(RES_W)) u_reg (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .cmp_i,
    .ptr_i(ptr), .code_o(code), .trial_o
  );

  sar_result #(.RES_W(RES_W)) u_res (
    .clk_i, .rst_ni, .load_i(load), .latch_i(latch), .code_i(code),
    .result_o, .valid_o, .eoc_o
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             eoc_o,
  input logic             valid_o,
  input logic             short_q,
  input logic [RES_W-1:0] trial_o,
  input logic [RES_W-1:0] result_o
);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};
  localparam int LOW_W = RES_W - SHORT_W;

  assert_start_msb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (trial_o == MSB_ONLY) && $past(start_i));

  assert_short_low_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && short_q) |-> (trial_o[LOW_W-1:0] == '0));

  assert_busy_ends_eoc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> eoc_o);

  assert_no_data_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!valid_o && result_o == '0));

  assert_eoc_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> (valid_o && !busy_o) ##1 !eoc_o);

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> $stable(result_o));
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .eoc_o(eoc_o), .valid_o(valid_o), .short_q(short_q),
  .trial_o(trial_o), .result_o(result_o)
);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        short_sel = 1'b0;
  logic        cmp;
  logic [11:0] vin = '0;
  logic [11:0] trial, result;
  logic        busy, eoc, valid;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { logic [11:0] code; int cycles; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  assign cmp = (trial <= vin);  // ideal DAC/comparator model

  sar_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .short_i(short_sel),
    .cmp_i(cmp), .trial_o(trial), .busy_o(busy), .eoc_o(eoc),
    .valid_o(valid), .result_o(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // driver: one conversion, optional mid-run start poke
  task automatic convert(input logic [11:0] v, input logic sh, input bit poke);
    exp_t e;
    e.code   = sh ? {v[11:4], 4'h0} : v;
    e.cycles = sh ? 9 : 13;
    sb.push_back(e);
    @(negedge clk);
    vin = v; short_sel = sh; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", busy, 1);
    check("R2 trial", trial, 12'h800);
    check("R8 valid", valid, 0);
    check("R8 result", result, 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1; short_sel = ~sh;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R7 no restart", busy, 0);
    check("R10 hold", result, e.code);
  endtask

  // monitor: busy length and result at each end pulse
  int busy_cnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (busy) busy_cnt++;
      if (eoc) begin
        if (sb.size() == 0) begin
          check("R9 unexpected eoc", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check("R4/R5 result", result, e.code);
          check("R6 busy cycles", busy_cnt, e.cycles);
          check("R9 valid", valid, 1);
        end
        busy_cnt = 0;
        @(negedge clk);
        check("R9 eoc one cycle", eoc, 0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 eoc", eoc, 0);
    check("R1 valid", valid, 0);
    check("R1 result", result, 0);
    check("R1 trial", trial, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 R4 full-length patterns
    convert(12'h000, 0, 0);
    convert(12'hFFF, 0, 0);
    convert(12'h800, 0, 0);
    convert(12'h7FF, 0, 0);
    convert(12'hA5A, 0, 0);
    convert(12'h555, 0, 0);
    // R5 short patterns
    convert(12'hFFF, 1, 0);
    convert(12'h123, 1, 0);
    convert(12'h00F, 1, 0);
    // R7 pokes during both modes
    convert(12'h9C7, 0, 1);
    convert(12'h3E9, 1, 1);
    // R10 hold over idle time
    repeat (20) @(negedge clk);
    check("R10 long hold", result, 12'h3E0);
    repeat (3) @(negedge clk);
    check("R4 scoreboard empty", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule